// File: doc/BRIEF.md
# Write-Status Bit Generator

This block builds the word a parallel flash returns on its data bus while an internal program or erase is running or while an erase is suspended. The command logic tells it when an operation starts and ends, whether that operation is a program or an erase, whether an erase is currently suspended, and which sector or block the suspended erase covers. The block also receives the true value of bit 7 of the word being programmed. On each read strobe it produces a registered output word in which bit 7 is a polling bit, bit 6 is the main toggle bit and bit 2 is the secondary toggle bit. All other bits pass the array word through unchanged. The block also drives an active-low busy indication.

The block keeps two independent toggle flip-flops. Which of them flips on a read depends on the running operation and on whether the read address falls inside the suspended region. The region is one sector (2^SECT_BITS words) or one block (2^BLOCK_BITS words), chosen by an input. A program started during a suspended erase has its own active flag. When that program ends, the block returns to suspended status, and when the suspend is released the erase status comes back.

Top module: `wsgTop`

## Requirements
- R1: During reset and on the first clock after it, `dqOut` is 0, `rdValid` is 0 and `busyN` is 1.
- R2: `busyN` goes low in the clock after a `startStb` that starts a program, or an erase with `suspIn` low. It returns high in the clock after the matching `doneStb`. It is high while an erase is suspended and no program is running.
- R3: For a read during a program, bit 7 of `dqOut` is the inverse of `progMsb`. Bit 2 and every bit other than 7 and 6 equal the array word.
- R4: For successive reads during a program, bit 6 alternates 0, 1, 0, … starting from 0.
- R5: For a read during a running erase, bit 7 is 0. Bits 6 and 2 each alternate starting from 0, and the other bits equal the array word.
- R6: For a read during a suspended erase whose address lies in the suspended region, bits 7 and 6 are 1, bit 2 alternates, and bit 6's toggle state is not advanced.
- R7: For a read during a suspended erase outside the suspended region, `dqOut` equals the array word and neither toggle state advances.
- R8: When `suspIsBlock` is 0, the region is the set of addresses sharing `suspAddr` above bit SECT_BITS-1 (default 11). When `suspIsBlock` is 1, the boundary is BLOCK_BITS (default 15).
- R9: For a read with no operation active or suspended, `dqOut` equals the array word.
- R10: A program started while an erase is suspended reports program status at any address and drives `busyN` low. After its `doneStb`, suspended status and a high `busyN` return. Releasing `suspIn` then resumes erase status with `busyN` low.
- R11: `rdValid` is high exactly in the clock after `rdStb`, and `dqOut` holds its value between reads.
- R12: Every `startStb` clears both toggle states, so the first read after a start shows 0 on any toggling bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | One-clock pulse at the end of the final command write |
| startErase | input | 1 | With `startStb`: 1 starts an erase, 0 a program |
| doneStb | input | 1 | One-clock pulse when the running program (else erase) completes |
| suspIn | input | 1 | Level: the erase is suspended |
| suspIsBlock | input | 1 | 1: suspended region is a block, 0: a sector |
| suspAddr | input | AW | Any word address inside the suspended region |
| rdStb | input | 1 | Read strobe |
| rdAddr | input | AW | Read address |
| arrayData | input | DW | Array word at `rdAddr` |
| progMsb | input | 1 | True bit 7 of the word being programmed |
| dqOut | output | DW | Registered read word |
| rdValid | output | 1 | `dqOut` was updated this clock |
| busyN | output | 1 | Low while an operation is running |

## Verification
The hardest state to reach is the nested one: a program running inside a suspended erase. The bench must then show that both the erase and its suspend survive that program. It gets there by starting an erase, suspending it, reading inside and outside the region in both sector and block size, and then starting and finishing a program. Only after that does it release the suspend. A mirror of the toggle states in the bench predicts every read, so a toggle that advances when it should be frozen shows up on a later read.

// File: rtl/wsgPkg.sv
`timescale 1ns/1ps
package wsgPkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_ERASE = 2'd2,
    MODE_SUSP  = 2'd3
  } statMode_e;

  typedef struct packed {
    statMode_e mode;
    logic      inRegion;
    logic      clrTog;
    logic      flip6;
    logic      flip2;
  } ctlStb_t;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int ALT_BIT  = 2;
endpackage

// File: rtl/wsgCtrl.sv
`timescale 1ns/1ps
module wsgCtrl
  import wsgPkg::*;
#(
  parameter int AW         = 21,
  parameter int SECT_BITS  = 11,
  parameter int BLOCK_BITS = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startStb,
  input  logic          startErase,
  input  logic          doneStb,
  input  logic          suspIn,
  input  logic          suspIsBlock,
  input  logic [AW-1:0] suspAddr,
  input  logic [AW-1:0] rdAddr,
  output ctlStb_t       ctl,
  output logic          busyN
);
  localparam logic [AW-1:0] SECT_MASK  = {AW{1'b1}} << SECT_BITS;
  localparam logic [AW-1:0] BLOCK_MASK = {AW{1'b1}} << BLOCK_BITS;

  logic progActive;
  logic eraseActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progActive  <= 1'b0;
      eraseActive <= 1'b0;
    end else if (startStb) begin
      if (startErase) eraseActive <= 1'b1;
      else            progActive  <= 1'b1;
    end else if (doneStb) begin
      if (progActive) progActive  <= 1'b0;
      else            eraseActive <= 1'b0;
    end
  end

  logic [AW-1:0] addrDiff;
  logic          regionHit;
  statMode_e     modeNow;

  always_comb begin
    addrDiff  = rdAddr ^ suspAddr;
    regionHit = suspIsBlock ? ((addrDiff & BLOCK_MASK) == '0)
                            : ((addrDiff & SECT_MASK) == '0);
    if (progActive)       modeNow = MODE_PROG;
    else if (suspIn)      modeNow = MODE_SUSP;
    else if (eraseActive) modeNow = MODE_ERASE;
    else                  modeNow = MODE_IDLE;
  end

  always_comb begin
    ctl.mode     = modeNow;
    ctl.inRegion = regionHit;
    ctl.clrTog   = startStb;
    ctl.flip6    = (modeNow == MODE_PROG) || (modeNow == MODE_ERASE);
    ctl.flip2    = (modeNow == MODE_ERASE) || ((modeNow == MODE_SUSP) && regionHit);
  end

  assign busyN = !(progActive || (eraseActive && !suspIn));
endmodule

// File: rtl/wsgDatapath.sv
`timescale 1ns/1ps
module wsgDatapath
  import wsgPkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStb_t       ctl,
  input  logic          rdStb,
  input  logic [DW-1:0] arrayData,
  input  logic          progMsb,
  output logic [DW-1:0] dqOut,
  output logic          rdValid
);
  logic tog6;
  logic tog2;
  logic [DW-1:0] statWord;

  always_comb begin
    statWord = arrayData;
    unique case (ctl.mode)
      MODE_PROG: begin
        statWord[POLL_BIT] = ~progMsb;
        statWord[TOG_BIT]  = tog6;
      end
      MODE_ERASE: begin
        statWord[POLL_BIT] = 1'b0;
        statWord[TOG_BIT]  = tog6;
        statWord[ALT_BIT]  = tog2;
      end
      MODE_SUSP: begin
        if (ctl.inRegion) begin
          statWord[POLL_BIT] = 1'b1;
          statWord[TOG_BIT]  = 1'b1;
          statWord[ALT_BIT]  = tog2;
        end
      end
      default: statWord = arrayData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tog6    <= 1'b0;
      tog2    <= 1'b0;
      dqOut   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdStb;
      if (rdStb) dqOut <= statWord;
      if (ctl.clrTog) begin
        tog6 <= 1'b0;
        tog2 <= 1'b0;
      end else if (rdStb) begin
        if (ctl.flip6) tog6 <= ~tog6;
        if (ctl.flip2) tog2 <= ~tog2;
      end
    end
  end
endmodule

// File: rtl/wsgTop.sv
`timescale 1ns/1ps
module wsgTop
  import wsgPkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 21,
  parameter int SECT_BITS  = 11,
  parameter int BLOCK_BITS = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startStb,
  input  logic          startErase,
  input  logic          doneStb,
  input  logic          suspIn,
  input  logic          suspIsBlock,
  input  logic [AW-1:0] suspAddr,
  input  logic          rdStb,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] arrayData,
  input  logic          progMsb,
  output logic [DW-1:0] dqOut,
  output logic          rdValid,
  output logic          busyN
);
  ctlStb_t ctl;

  wsgCtrl #(.AW(AW), .SECT_BITS(SECT_BITS), .BLOCK_BITS(BLOCK_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startErase(startErase),
    .doneStb(doneStb), .suspIn(suspIn), .suspIsBlock(suspIsBlock),
    .suspAddr(suspAddr), .rdAddr(rdAddr), .ctl(ctl), .busyN(busyN)
  );

  wsgDatapath #(.DW(DW)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdStb(rdStb), .arrayData(arrayData),
    .progMsb(progMsb), .dqOut(dqOut), .rdValid(rdValid)
  );
endmodule

// File: rtl/wsgChecker.sv
`timescale 1ns/1ps
module wsgChecker
  import wsgPkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          startStb,
  input logic          startErase,
  input logic          busyN,
  input logic          rdStb,
  input logic          rdValid,
  input logic [DW-1:0] dqOut,
  input logic [DW-1:0] arrayData,
  input logic          progMsb,
  input ctlStb_t       ctl
);
  a_r2_busy_on_program: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !startErase) |=> !busyN);

  a_r2_ready_in_suspend: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_SUSP) |-> busyN);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> rdValid);

  a_r11_valid_only: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> !rdValid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> $stable(dqOut));

  a_r3_poll_inverse: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(ctl.mode == MODE_PROG)) |-> (dqOut[POLL_BIT] == !$past(progMsb)));

  a_r5_erase_poll_low: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(ctl.mode == MODE_ERASE)) |-> !dqOut[POLL_BIT]);

  a_r6_region_high: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(ctl.mode == MODE_SUSP && ctl.inRegion)) |->
      (dqOut[POLL_BIT] && dqOut[TOG_BIT]));

  a_r7_outside_pass: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(ctl.mode == MODE_SUSP && !ctl.inRegion)) |->
      (dqOut == $past(arrayData)));
endmodule

bind wsgTop wsgChecker #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .startErase(startErase),
  .busyN(busyN), .rdStb(rdStb), .rdValid(rdValid), .dqOut(dqOut),
  .arrayData(arrayData), .progMsb(progMsb), .ctl(ctl)
);

// File: tb/wsgTop_test.sv
`timescale 1ns/1ps
module wsgTop_test;
  localparam int DW = 16;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rstN;
  logic          startStb, startErase, doneStb, suspIn, suspIsBlock;
  logic [AW-1:0] suspAddr, rdAddr;
  logic          rdStb;
  logic [DW-1:0] arrayData;
  logic          progMsb;
  logic [DW-1:0] dqOut;
  logic          rdValid, busyN;

  always #2.5 clk = ~clk;

  wsgTop uut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startErase(startErase),
    .doneStb(doneStb), .suspIn(suspIn), .suspIsBlock(suspIsBlock),
    .suspAddr(suspAddr), .rdStb(rdStb), .rdAddr(rdAddr), .arrayData(arrayData),
    .progMsb(progMsb), .dqOut(dqOut), .rdValid(rdValid), .busyN(busyN)
  );

  // Program-phase read vectors: array word and true bit 7 being written.
  localparam logic [DW-1:0] VDATA [8] = '{16'h1234, 16'hFFFF, 16'h0000, 16'h00C4,
                                          16'h8080, 16'h7F7F, 16'hA5A5, 16'h0044};
  localparam logic [7:0] VMSB = 8'b1011_0010;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 0;

  // Mirror of the expected state, kept from the requirements.
  bit            pOn = 0, eOn = 0, sOn = 0, sBlk = 0;
  logic [AW-1:0] sAddr = '0;
  bit            t6 = 0, t2 = 0;
  logic          pMsb = 1'b0;
  logic [DW-1:0] lastOut;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readChk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] e;
    bit inR;
    e   = d;
    inR = sBlk ? ((a >> 15) == (sAddr >> 15)) : ((a >> 11) == (sAddr >> 11));
    if (pOn) begin
      e[7] = ~pMsb; e[6] = t6; t6 = ~t6;
    end else if (sOn) begin
      if (inR) begin e[7] = 1'b1; e[6] = 1'b1; e[2] = t2; t2 = ~t2; end
    end else if (eOn) begin
      e[7] = 1'b0; e[6] = t6; e[2] = t2; t6 = ~t6; t2 = ~t2;
    end
    @(negedge clk);
    rdStb = 1'b1; rdAddr = a; arrayData = d; progMsb = pMsb;
    @(negedge clk);
    rdStb = 1'b0;
    check({tag, " (R11 valid)"}, 32'(rdValid), 32'd1);
    check(tag, 32'(dqOut), 32'(e));
    lastOut = dqOut;
  endtask

  task automatic startOp(input bit er);
    @(negedge clk);
    startStb = 1'b1; startErase = er;
    @(negedge clk);
    startStb = 1'b0;
    if (er) eOn = 1; else pOn = 1;
    t6 = 0; t2 = 0;
  endtask

  task automatic doneOp();
    @(negedge clk);
    doneStb = 1'b1;
    @(negedge clk);
    doneStb = 1'b0;
    if (pOn) pOn = 0; else eOn = 0;
  endtask

  task automatic setSusp(input bit on, input bit blk, input logic [AW-1:0] a);
    @(negedge clk);
    suspIn = on; suspIsBlock = blk; suspAddr = a;
    sOn = on; sBlk = blk; sAddr = a;
    @(negedge clk);
  endtask

  task automatic busyChk(input string tag);
    check(tag, 32'(busyN), 32'(!(pOn || (eOn && !sOn))));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0; startStb = 0; startErase = 0; doneStb = 0; suspIn = 0;
    suspIsBlock = 0; suspAddr = '0; rdStb = 0; rdAddr = '0; arrayData = '0; progMsb = 0;
    repeat (3) @(negedge clk);
    check("R1 dqOut reset", 32'(dqOut), 32'd0);
    check("R1 rdValid reset", 32'(rdValid), 32'd0);
    check("R1 busyN reset", 32'(busyN), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 dqOut after reset", 32'(dqOut), 32'd0);

    readChk("R9 idle pass", 21'h000100, 16'hA5A5);

    // Program: table walk
    startOp(1'b0);
    busyChk("R2 busy during program");
    for (int i = 0; i < 8; i++) begin
      pMsb = VMSB[i];
      readChk("R3 R4 program status", AW'(i * 3), VDATA[i]);
    end
    doneOp();
    busyChk("R2 ready after program");
    readChk("R9 pass after program", 21'h1FFFFF, 16'h5AC3);

    // R11: output held between reads
    repeat (3) @(negedge clk);
    check("R11 no valid without strobe", 32'(rdValid), 32'd0);
    check("R11 dqOut held", 32'(dqOut), 32'(lastOut));

    // Erase
    startOp(1'b1);
    busyChk("R2 busy during erase");
    readChk("R5 erase status", 21'h000010, 16'hFFFF);
    readChk("R5 erase status", 21'h012345, 16'h0000);
    readChk("R5 erase status", 21'h1F0000, 16'h1234);

    // Suspend, sector region
    setSusp(1'b1, 1'b0, 21'h012345);
    busyChk("R2 ready in suspend");
    readChk("R6 sector region", 21'h012000, 16'hFFFF);
    readChk("R6 sector region", 21'h0127FF, 16'h0000);
    readChk("R7 outside sector", 21'h013000, 16'hBEEF);
    readChk("R7 outside sector", 21'h011FFF, 16'h0000);
    readChk("R6 toggle after outside reads", 21'h012100, 16'h0000);

    // R8: block region
    setSusp(1'b1, 1'b1, 21'h012345);
    readChk("R8 block region hit", 21'h013000, 16'h0F0F);
    readChk("R8 block region miss", 21'h018000, 16'h0F0F);

    // R10: program inside suspend
    pMsb = 1'b0;
    startOp(1'b0);
    busyChk("R10 busy nested program");
    readChk("R10 nested program status", 21'h012345, 16'h00FF);
    readChk("R10 nested program status", 21'h100000, 16'h00FF);
    doneOp();
    busyChk("R10 ready after nested program");
    readChk("R10 suspend status back", 21'h012345, 16'h3333);

    // Resume erase
    setSusp(1'b0, 1'b1, 21'h012345);
    busyChk("R10 busy after resume");
    readChk("R10 R5 erase after resume", 21'h012345, 16'hFFFF);
    readChk("R10 R5 erase after resume", 21'h000000, 16'hFFFF);
    doneOp();
    busyChk("R2 ready after erase");

    // R12: fresh start clears toggles
    startOp(1'b1);
    readChk("R12 first read after start", 21'h000020, 16'hFFFF);
    check("R12 DQ6 cleared", 32'(dqOut[6]), 32'd0);
    check("R12 DQ2 cleared", 32'(dqOut[2]), 32'd0);
    doneOp();
    readChk("R9 idle after erase", 21'h000020, 16'h4C4C);

    finish();
  end
endmodule